// File: doc/BRIEF.md
# Memory Thermal Trip Throttler

This block watches a memory temperature reading and turns it into two controls for the memory subsystem. One is a throttle level, a 4-bit fraction in sixteenths, that a request limiter elsewhere uses to hold back memory traffic. The other is a shutdown request for the platform. The reading arrives on one input with a valid strobe. The block works the same whether the value comes from an external sensor report or from an estimate based on activity.

Software programs three ordered trip temperatures (warm, hot, critical), a throttle amount for the warm band and one for the hot band, and a hysteresis margin. When the temperature rises past the warm or the hot trip, the matching amount is applied, and the hot amount wins whenever both trips are exceeded. A level is released only once the temperature has dropped by the hysteresis margin, which keeps the output from chattering around a threshold. Crossing the critical trip raises a shutdown request that stays high until reset.

Top module: `mem_trip_throttle`

## Requirements
- R1: After reset, throttleAmt is 0 and shutdownReq is 0. The warm, hot and critical trips read 255, and both amounts and the hysteresis read 0.
- R2: Register map on regAddr: 0 warm trip, 1 hot trip, 2 critical trip, 3 warm amount (bits 3:0), 4 hot amount (bits 3:0), 5 hysteresis. A write takes effect on the clock edge where regWrEn is high. regRdData shows the addressed register combinationally, with amount registers zero-extended. Addresses 6 and 7 read 0 and ignore writes.
- R3: Temperatures are evaluated only on a clock edge where tempValid is high. Between strobes throttleAmt holds its value, even when the amount registers are rewritten.
- R4: On a strobe with temp above the warm trip (strictly greater) and not above the hot trip, starting from no throttling, throttleAmt equals the warm amount from the next cycle.
- R5: On a strobe with temp above the hot trip, throttleAmt equals the hot amount from the next cycle, whatever the warm comparison gives.
- R6: An active level is kept while temp + hysteresis is greater than that level's trip. A hot level falls back to warm if only the warm band still holds, and to none if neither band holds.
- R7: On a strobe with temp above the critical trip, shutdownReq is 1 from the next cycle. Critical does not change the throttle amount.
- R8: Once set, shutdownReq stays 1 until reset, even when the temperature falls.
- R9: A strobe with temp at or below the warm trip, while no level holds, drives throttleAmt to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| tempValid | input | 1 | Temperature strobe |
| temp | input | 8 | Temperature, unsigned whole degrees |
| throttleAmt | output | 4 | Throttle level in sixteenths |
| shutdownReq | output | 1 | Sticky shutdown request |

## Verification
The bench builds the block with its default widths: 8-bit temperatures, 4-bit amounts and a 3-bit address. At these widths every temperature value can be swept. With trips at 100, 150 and 200 and a margin of 5, each of the 256 temperatures is applied from three starting states: none, warm and hot. This reaches every threshold edge and every edge of each hysteresis band. Every register address is written and read back, and a mid-run reset shows that the sticky shutdown clears.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_WARM = 2'd1,
    LVL_HOT  = 2'd2
  } level_t;

  // trip index order used by the comparator array
  localparam int TRIP_WARM = 0;
  localparam int TRIP_HOT  = 1;
  localparam int TRIP_CRIT = 2;
  localparam int NUM_TRIPS = 3;

  // register addresses
  localparam int ADR_WARM_THR = 0;
  localparam int ADR_HOT_THR  = 1;
  localparam int ADR_CRIT_THR = 2;
  localparam int ADR_WARM_AMT = 3;
  localparam int ADR_HOT_AMT  = 4;
  localparam int ADR_HYST     = 5;

  // datapath comparison results
  typedef struct packed {
    logic aboveWarm;
    logic aboveHot;
    logic aboveCrit;
    logic holdWarm;
    logic holdHot;
  } cmpFlags_t;

  // control to datapath strobes
  typedef struct packed {
    logic   loadThrottle;
    level_t selLevel;
  } ctrlStrobes_t;

endpackage

// File: rtl/mtt_datapath.sv
module mtt_datapath
  import mtt_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int AMT_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TEMP_W-1:0] regWrData,
  output logic [TEMP_W-1:0] regRdData,
  input  logic [TEMP_W-1:0] temp,
  output cmpFlags_t         flags,
  input  ctrlStrobes_t      strobes,
  output logic [AMT_W-1:0]  throttleAmt
);

  localparam int SUM_W = TEMP_W + 1;
  localparam logic [TEMP_W-1:0] THR_RESET = {TEMP_W{1'b1}};

  logic [TEMP_W-1:0] tripThr [NUM_TRIPS];
  logic [AMT_W-1:0]  warmAmt;
  logic [AMT_W-1:0]  hotAmt;
  logic [TEMP_W-1:0] hystVal;
  logic [NUM_TRIPS-1:0] aboveVec;
  logic [NUM_TRIPS-1:0] holdVec;
  logic [SUM_W-1:0]  tempPlusHyst;

  assign tempPlusHyst = {1'b0, temp} + {1'b0, hystVal};

  // trip threshold registers and comparators, one slice per trip
  for (genvar gi = 0; gi < NUM_TRIPS; gi++) begin : g_trip
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tripThr[gi] <= THR_RESET;
      end else if (regWrEn && regAddr == ADDR_W'(gi)) begin
        tripThr[gi] <= regWrData;
      end
    end
    assign aboveVec[gi] = temp > tripThr[gi];
    assign holdVec[gi]  = tempPlusHyst > {1'b0, tripThr[gi]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warmAmt <= '0;
      hotAmt  <= '0;
      hystVal <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(ADR_WARM_AMT)) warmAmt <= regWrData[AMT_W-1:0];
      if (regAddr == ADDR_W'(ADR_HOT_AMT))  hotAmt  <= regWrData[AMT_W-1:0];
      if (regAddr == ADDR_W'(ADR_HYST))     hystVal <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADR_WARM_THR))      regRdData = tripThr[TRIP_WARM];
    else if (regAddr == ADDR_W'(ADR_HOT_THR))  regRdData = tripThr[TRIP_HOT];
    else if (regAddr == ADDR_W'(ADR_CRIT_THR)) regRdData = tripThr[TRIP_CRIT];
    else if (regAddr == ADDR_W'(ADR_WARM_AMT)) regRdData = TEMP_W'(warmAmt);
    else if (regAddr == ADDR_W'(ADR_HOT_AMT))  regRdData = TEMP_W'(hotAmt);
    else if (regAddr == ADDR_W'(ADR_HYST))     regRdData = hystVal;
  end

  always_comb begin
    flags.aboveWarm = aboveVec[TRIP_WARM];
    flags.aboveHot  = aboveVec[TRIP_HOT];
    flags.aboveCrit = aboveVec[TRIP_CRIT];
    flags.holdWarm  = holdVec[TRIP_WARM];
    flags.holdHot   = holdVec[TRIP_HOT];
  end

  // throttle output register, loaded only on a control strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      throttleAmt <= '0;
    end else if (strobes.loadThrottle) begin
      case (strobes.selLevel)
        LVL_HOT:  throttleAmt <= hotAmt;
        LVL_WARM: throttleAmt <= warmAmt;
        default:  throttleAmt <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mtt_control.sv
module mtt_control
  import mtt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tempValid,
  input  cmpFlags_t    flags,
  output ctrlStrobes_t strobes,
  output logic         shutdownReq
);

  level_t curLevel;
  level_t nextLevel;
  logic   keepHot;
  logic   keepWarm;

  assign keepHot  = (curLevel == LVL_HOT) && flags.holdHot;
  assign keepWarm = (curLevel != LVL_NONE) && flags.holdWarm;

  always_comb begin
    if (flags.aboveHot || keepHot) begin
      nextLevel = LVL_HOT;
    end else if (flags.aboveWarm || keepWarm) begin
      nextLevel = LVL_WARM;
    end else begin
      nextLevel = LVL_NONE;
    end
  end

  assign strobes.loadThrottle = tempValid;
  assign strobes.selLevel     = nextLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel    <= LVL_NONE;
      shutdownReq <= 1'b0;
    end else if (tempValid) begin
      curLevel <= nextLevel;
      if (flags.aboveCrit) shutdownReq <= 1'b1;
    end
  end

endmodule

// File: rtl/mem_trip_throttle.sv
module mem_trip_throttle
  import mtt_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int AMT_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TEMP_W-1:0] regWrData,
  output logic [TEMP_W-1:0] regRdData,
  input  logic              tempValid,
  input  logic [TEMP_W-1:0] temp,
  output logic [AMT_W-1:0]  throttleAmt,
  output logic              shutdownReq
);

  cmpFlags_t    cmpFlags;
  ctrlStrobes_t ctrlStrobes;

  mtt_datapath #(
    .TEMP_W(TEMP_W),
    .AMT_W (AMT_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .temp       (temp),
    .flags      (cmpFlags),
    .strobes    (ctrlStrobes),
    .throttleAmt(throttleAmt)
  );

  mtt_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tempValid  (tempValid),
    .flags      (cmpFlags),
    .strobes    (ctrlStrobes),
    .shutdownReq(shutdownReq)
  );

endmodule

// File: rtl/mtt_checker.sv
module mtt_checker
  import mtt_pkg::*;
#(
  parameter int AMT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             tempValid,
  input logic             shutdownReq,
  input logic [AMT_W-1:0] throttleAmt,
  input cmpFlags_t        flags,
  input ctrlStrobes_t     strobes
);

  a_r8_shutdown_sticky: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |=> shutdownReq);

  a_r7_shutdown_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdownReq) |-> $past(tempValid));

  a_r7_crit_sets_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && flags.aboveCrit) |=> shutdownReq);

  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |=> $stable(throttleAmt));

  a_r5_hot_wins: assert property (@(posedge clk) disable iff (!rstN)
    (tempValid && flags.aboveHot) |-> (strobes.selLevel == LVL_HOT));

endmodule

bind mem_trip_throttle mtt_checker #(.AMT_W(AMT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tempValid  (tempValid),
  .shutdownReq(shutdownReq),
  .throttleAmt(throttleAmt),
  .flags      (cmpFlags),
  .strobes    (ctrlStrobes)
);

// File: tb/mem_trip_throttle_tb.sv
module mem_trip_throttle_tb;

  localparam int WARM_T = 100;
  localparam int HOT_T  = 150;
  localparam int CRIT_T = 200;
  localparam int HYST   = 5;
  localparam int WARM_A = 3;
  localparam int HOT_A  = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       tempValid = 1'b0;
  logic [7:0] temp = '0;
  logic [3:0] throttleAmt;
  logic       shutdownReq;

  int errors = 0;
  int checks = 0;
  int expLevel = 0;  // 0 none, 1 warm, 2 hot
  logic expShut = 1'b0;

  always #2.5 clk = ~clk;

  mem_trip_throttle u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tempValid(tempValid),
    .temp(temp), .throttleAmt(throttleAmt), .shutdownReq(shutdownReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int adr, input int val);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(adr); regWrData = 8'(val);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input int adr, input int exp);
    @(negedge clk);
    regAddr = 3'(adr);
    #1;
    check(req, int'(regRdData), exp);
  endtask

  function automatic int modelNext(input int cur, input int t);
    if (t > HOT_T || (cur == 2 && t + HYST > HOT_T)) return 2;
    if (t > WARM_T || (cur != 0 && t + HYST > WARM_T)) return 1;
    return 0;
  endfunction

  function automatic int levelAmt(input int lvl);
    return (lvl == 2) ? HOT_A : (lvl == 1) ? WARM_A : 0;
  endfunction

  task automatic applyTemp(input int t);
    @(negedge clk);
    tempValid = 1'b1; temp = 8'(t);
    @(negedge clk);
    tempValid = 1'b0;
    expLevel = modelNext(expLevel, t);
    if (t > CRIT_T) expShut = 1'b1;
  endtask

  task automatic configure();
    writeReg(0, WARM_T);
    writeReg(1, HOT_T);
    writeReg(2, CRIT_T);
    writeReg(3, 8'hF0 | WARM_A);
    writeReg(4, HOT_A);
    writeReg(5, HYST);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 throttle", int'(throttleAmt), 0);
    check("R1 shutdown", int'(shutdownReq), 0);
    for (int a = 0; a < 8; a++)
      readCheck("R1 reset reg", a, (a < 3) ? 255 : 0);

    // R2 register map and ignored addresses
    configure();
    writeReg(6, 8'h5A);
    writeReg(7, 8'hA5);
    readCheck("R2 warm trip", 0, WARM_T);
    readCheck("R2 hot trip", 1, HOT_T);
    readCheck("R2 crit trip", 2, CRIT_T);
    readCheck("R2 warm amount", 3, WARM_A);
    readCheck("R2 hot amount", 4, HOT_A);
    readCheck("R2 hysteresis", 5, HYST);
    readCheck("R2 addr6", 6, 0);
    readCheck("R2 addr7", 7, 0);

    // R4 R5 R9 R7 R8: sweep from no level
    for (int t = 0; t < 256; t++) begin
      applyTemp(0);
      check("R9 cleared", int'(throttleAmt), 0);
      applyTemp(t);
      check("R4/R5/R9 level amount", int'(throttleAmt), levelAmt(expLevel));
      check("R7/R8 shutdown", int'(shutdownReq), int'(expShut));
    end

    // R6 hysteresis from the hot level
    for (int t = 0; t < 256; t++) begin
      applyTemp(160);
      applyTemp(t);
      check("R6 from hot", int'(throttleAmt), levelAmt(expLevel));
    end
    // R6 hysteresis from the warm level
    for (int t = 0; t < 256; t++) begin
      applyTemp(0);
      applyTemp(120);
      applyTemp(t);
      check("R6 from warm", int'(throttleAmt), levelAmt(expLevel));
    end

    // R8 shutdown stays up after cooling
    applyTemp(0);
    repeat (5) @(negedge clk);
    check("R8 sticky after cooling", int'(shutdownReq), 1);

    // R3 output holds between strobes
    applyTemp(120);
    check("R3 warm before rewrite", int'(throttleAmt), WARM_A);
    writeReg(3, 12);
    repeat (3) @(negedge clk);
    check("R3 held after amount rewrite", int'(throttleAmt), WARM_A);
    @(negedge clk);
    temp = 8'd250;
    repeat (2) @(negedge clk);
    check("R3 temp change without strobe", int'(throttleAmt), WARM_A);
    applyTemp(120);
    check("R3 new amount on strobe", int'(throttleAmt), 12);

    // R1 reset clears sticky shutdown
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expShut = 1'b0; expLevel = 0;
    @(negedge clk);
    check("R1 shutdown cleared", int'(shutdownReq), 0);
    check("R1 throttle cleared", int'(throttleAmt), 0);
    readCheck("R1 warm trip restored", 0, 255);

    // R7 critical alone does not change the throttle amount
    configure();
    applyTemp(230);
    check("R7 shutdown on crit", int'(shutdownReq), 1);
    check("R7 throttle is hot amount", int'(throttleAmt), HOT_A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule